// File: doc/BRIEF.md
# Software-Triggered Reset Pin Controller

This block runs a bidirectional, open-drain reset pin. As an output, it drives a fixed-length active-low pulse when software writes a one to a request bit. The pulse is allowed only when a separate enable bit is set. The request bit clears itself when the pulse starts, or when the request is refused. As an input, the pin is watched for an external low level. A low that lasts long enough raises a one-cycle strobe, and that strobe returns the registers that have power-on defaults to those defaults. The data-converter setting, the measured values and the programmed limits are outside that set.

The pin is modelled as a drive-low enable together with the level sampled back from the pad. The block never treats its own pulse as an external reset. The pulse length is `(CLK_HZ/1000) * PULSE_MS` clock cycles, which is 20 ms at the default settings. A simulation build uses a smaller clock figure so that the pulse is only a few cycles long.

Top module: `srp_reset_pin`

## Requirements
- R1: While `rst` is high, and in the cycle after `rst` is released, `pin_drive_low`, `req_bit` and `defaults_rst` are all 0.
- R2: A write (`cfg_wr`=1 with `cfg_req_wdata`=1) accepted while idle with `pulse_en`=1 makes `req_bit` read 1 in the following cycle. `pin_drive_low` rises one cycle after that and stays high for exactly `(CLK_HZ/1000)*PULSE_MS` cycles.
- R3: The request bit clears itself on the same edge that starts the pulse, so `req_bit` is never high for two consecutive cycles.
- R4: A request written while `pulse_en`=0 leaves `req_bit` at 0 and starts no pulse. If `pulse_en` falls while a request is pending, the request is dropped without a pulse.
- R5: A request written while the pulse is being driven is ignored. `req_bit` stays 0 and the pulse length is unchanged.
- R6: An external low that holds `pin_sense` at 0 for two or more consecutive clock samples gives exactly one one-cycle `defaults_rst` pulse. The pulse is visible after the third edge following the first low sample, whatever the length of the low.
- R7: An external low that lasts a single clock sample produces no `defaults_rst`.
- R8: The block's own pulse never raises `defaults_rst`. This includes the synchroniser settling cycles after the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_wr | input | 1 | Write strobe for the configuration word holding the request bit |
| cfg_req_wdata | input | 1 | Value written to the request bit |
| pulse_en | input | 1 | Enable bit from the mask register; 1 allows the pulse |
| req_bit | output | 1 | Current request-bit value returned to software |
| pin_sense | input | 1 | Level sampled from the pad (0 = low) |
| pin_drive_low | output | 1 | Open-drain enable; 1 pulls the pad low |
| defaults_rst | output | 1 | One-cycle strobe that restores default-valued registers |

## Verification
A request is due on `req_bit` one edge after the write and on `pin_drive_low` two edges after it. The pulse then lasts the configured cycle count. An external low first appears on `defaults_rst` three edges after the first low sample: two synchroniser stages and one filter stage. The bench drives its inputs and samples the outputs on falling clock edges. It compares each output against these fixed offsets, counted from the edge that took the stimulus. It sweeps external low widths and counts both the strobes and the cycle in which each one appears. Pulse lengths are measured by counting high samples and compared with the length computed from the parameters.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    PG_IDLE    = 2'd0,
    PG_PENDING = 2'd1,
    PG_DRIVE   = 2'd2
  } pg_state_e;

  function automatic int unsigned pulse_cycles(input int unsigned clk_hz,
                                               input int unsigned pulse_ms);
    return (clk_hz / 1000) * pulse_ms;
  endfunction
endpackage

// File: rtl/srp_pulse_gen.sv
module srp_pulse_gen
  import srp_pkg::*;
#(
  parameter int unsigned PULSE_CYC = 2_000_000,
  parameter int unsigned GUARD_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_req_wdata,
  input  logic pulse_en,
  output logic req_bit,
  output logic drive_low,
  output logic sense_mask
);
  localparam int unsigned CNT_W   = $clog2(PULSE_CYC + 1);
  localparam int unsigned GUARD_W = $clog2(GUARD_CYC + 1);

  pg_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [GUARD_W-1:0] guard_q;
  logic              req_q, drv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PG_IDLE;
      cnt_q   <= '0;
      guard_q <= '0;
      req_q   <= 1'b0;
      drv_q   <= 1'b0;
    end else begin
      if (guard_q != '0) guard_q <= guard_q - 1'b1;
      unique case (st_q)
        PG_IDLE: begin
          if (cfg_wr && cfg_req_wdata && pulse_en) begin
            st_q  <= PG_PENDING;
            req_q <= 1'b1;
          end
        end
        PG_PENDING: begin
          req_q <= 1'b0;
          if (pulse_en) begin
            st_q  <= PG_DRIVE;
            drv_q <= 1'b1;
            cnt_q <= CNT_W'(PULSE_CYC - 1);
          end else begin
            st_q <= PG_IDLE;
          end
        end
        PG_DRIVE: begin
          if (cnt_q == '0) begin
            st_q    <= PG_IDLE;
            drv_q   <= 1'b0;
            guard_q <= GUARD_W'(GUARD_CYC);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= PG_IDLE;
      endcase
    end
  end

  assign req_bit    = req_q;
  assign drive_low  = drv_q;
  assign sense_mask = drv_q || (guard_q != '0);

  logic [CNT_W:0] run_len_q;
  always_ff @(posedge clk) begin
    if (rst || !drv_q) run_len_q <= '0;
    else               run_len_q <= run_len_q + 1'b1;
  end

  AST_PULSE_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_q) |-> (run_len_q == (CNT_W+1)'(PULSE_CYC))); // R2
  AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q) |-> ($past(pulse_en) && $past(req_q))); // R2
endmodule

// File: rtl/srp_pin_sync.sv
module srp_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic pin_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b1;
          else     chain_q[0] <= pin_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b1;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/srp_low_filter.sv
module srp_low_filter #(
  parameter int unsigned MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  input  logic mask,
  output logic fire
);
  localparam int unsigned LC_W = $clog2(MIN_LOW + 1);

  logic [LC_W-1:0] low_cnt_q;
  logic            fire_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q <= '0;
      fire_q    <= 1'b0;
    end else begin
      if (mask || level)                    low_cnt_q <= '0;
      else if (low_cnt_q != LC_W'(MIN_LOW)) low_cnt_q <= low_cnt_q + 1'b1;
      fire_q <= !mask && !level && (low_cnt_q == LC_W'(MIN_LOW - 1));
    end
  end

  assign fire = fire_q;

  AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    fire_q |=> !fire_q); // R6
endmodule

// File: rtl/srp_reset_pin.sv
module srp_reset_pin
  import srp_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned PULSE_MS    = 20,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_LOW     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_req_wdata,
  input  logic pulse_en,
  output logic req_bit,
  input  logic pin_sense,
  output logic pin_drive_low,
  output logic defaults_rst
);
  localparam int unsigned PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_MS);

  logic sense_mask, pin_level;

  srp_pulse_gen #(.PULSE_CYC(PULSE_CYC), .GUARD_CYC(SYNC_STAGES)) u_pulse (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_req_wdata(cfg_req_wdata),
    .pulse_en(pulse_en), .req_bit(req_bit), .drive_low(pin_drive_low),
    .sense_mask(sense_mask)
  );

  srp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_raw(pin_sense), .pin_sync(pin_level)
  );

  srp_low_filter #(.MIN_LOW(MIN_LOW)) u_filt (
    .clk(clk), .rst(rst), .level(pin_level), .mask(sense_mask),
    .fire(defaults_rst)
  );

  AST_REQ_SELF_CLEARS: assert property (@(posedge clk) disable iff (rst)
    req_bit |=> !req_bit); // R3
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !pulse_en) |=> !req_bit); // R4
  AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && pin_drive_low) |=> !req_bit); // R5
  AST_OWN_PULSE_MASKED: assert property (@(posedge clk) disable iff (rst)
    defaults_rst |-> (!$past(pin_drive_low) && !$past(pin_drive_low, 2)
                      && !$past(pin_drive_low, 3))); // R8
endmodule

// File: tb/srp_reset_pin_tb.sv
module srp_reset_pin_tb_top;
  localparam int unsigned CLK_HZ   = 8000;
  localparam int unsigned PULSE_MS = 2;
  localparam int EXP_LEN = (CLK_HZ / 1000) * PULSE_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0, cfg_req_wdata = 1'b0, pulse_en = 1'b0, ext_low = 1'b0;
  logic req_bit, pin_drive_low, defaults_rst, pin_sense;
  int n_checks = 0, n_fail = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  assign pin_sense = ~(pin_drive_low | ext_low);

  srp_reset_pin #(.CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_req_wdata(cfg_req_wdata),
    .pulse_en(pulse_en), .req_bit(req_bit), .pin_sense(pin_sense),
    .pin_drive_low(pin_drive_low), .defaults_rst(defaults_rst)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_req();
    @(negedge clk); cfg_wr = 1'b1; cfg_req_wdata = 1'b1;
    @(negedge clk); cfg_wr = 1'b0; cfg_req_wdata = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int len, strobes, hits, pos;
    repeat (3) @(negedge clk);
    check(pin_drive_low == 0 && req_bit == 0 && defaults_rst == 0, "R1 in reset",
          {pin_drive_low, req_bit, defaults_rst}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pin_drive_low == 0 && req_bit == 0 && defaults_rst == 0, "R1 after release",
          {pin_drive_low, req_bit, defaults_rst}, 0);

    // R2 R3 R8: normal pulse
    pulse_en = 1'b1;
    write_req();
    check(req_bit == 1, "R2 req visible", req_bit, 1);
    check(pin_drive_low == 0, "R2 not yet driving", pin_drive_low, 0);
    @(negedge clk);
    check(pin_drive_low == 1, "R2 pulse start", pin_drive_low, 1);
    check(req_bit == 0, "R3 auto-clear", req_bit, 0);
    len = 1; strobes = 0;
    for (int i = 0; i < EXP_LEN + 20; i++) begin
      @(negedge clk);
      if (pin_drive_low) len++;
      if (defaults_rst) strobes++;
    end
    check(len == EXP_LEN, "R2 pulse length", len, EXP_LEN);
    check(strobes == 0, "R8 own pulse masked", strobes, 0);

    // R4: enable low at write
    pulse_en = 1'b0;
    write_req();
    check(req_bit == 0, "R4 req refused", req_bit, 0);
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pin_drive_low || req_bit) hits++;
    end
    check(hits == 0, "R4 no pulse when disabled", hits, 0);

    // R4: enable drops while pending
    pulse_en = 1'b1;
    write_req();
    check(req_bit == 1, "R4 pending", req_bit, 1);
    pulse_en = 1'b0;
    @(negedge clk);
    check(req_bit == 0 && pin_drive_low == 0, "R4 pending dropped",
          {req_bit, pin_drive_low}, 0);
    hits = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pin_drive_low) hits++;
    end
    check(hits == 0, "R4 no late pulse", hits, 0);

    // R5: write during pulse
    pulse_en = 1'b1;
    write_req();
    @(negedge clk);
    len = 1; hits = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (pin_drive_low) len++;
    end
    cfg_wr = 1'b1; cfg_req_wdata = 1'b1;
    for (int i = 0; i < EXP_LEN + 10; i++) begin
      @(negedge clk);
      cfg_wr = 1'b0; cfg_req_wdata = 1'b0;
      if (pin_drive_low) len++;
      if (req_bit) hits++;
    end
    check(hits == 0, "R5 req stays clear", hits, 0);
    check(len == EXP_LEN, "R5 pulse length unchanged", len, EXP_LEN);

    // R6 R7: external low width sweep
    for (int w = 1; w <= 12; w++) begin
      strobes = 0; pos = -1;
      ext_low = 1'b1;
      for (int i = 1; i <= w + 8; i++) begin
        @(negedge clk);
        if (i == w) ext_low = 1'b0;
        if (defaults_rst) begin
          strobes++;
          if (pos < 0) pos = i;
        end
      end
      if (w < 2) begin
        check(strobes == 0, "R7 short low ignored", strobes, 0);
      end else begin
        check(strobes == 1, "R6 one strobe per low", strobes, 1);
        check(pos == 4, "R6 strobe timing", pos, 4);
      end
      repeat (3) @(negedge clk);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule